// File: doc/BRIEF.md
# Scoreboard Out-of-Order Issue Controller

This block is the dynamic scheduling control for a small execution cluster. There are five functional units: one integer/load unit, two multipliers, one adder and one divider. Instructions arrive in program order, one at a time. Each instruction carries an operation class, a destination register number and two source register numbers. The block moves every instruction through four phases: issue, operand read, execution and result write. Execution may start and finish out of order. Each unit keeps a status record: busy, destination, both sources, the unit producing each source, and a ready flag per source. A per-register table records which unit will write each register.

Only register numbers and control are modelled. Each unit is a fixed-latency countdown timer whose latency is a parameter. The block's own grant outputs tell the surrounding datapath when a unit may read its operands and when it may write its result. `issue_ready` tells the front end whether the instruction now on the input is accepted at the next clock edge. When an instruction is not accepted, the front end holds it, so no later instruction can pass it.

Top module: `sb_scoreboard`

## Requirements
- R1: After reset all units are free, the result table is empty, `issue_ready` is 1 for any presented instruction, and `rd_grant` and `wr_grant` are 0.
- R2: An instruction is accepted (`in_valid` and `issue_ready` both high at a clock edge) only if a unit of its class is free and no unit holds a pending write to its destination register. Otherwise `issue_ready` is low and the instruction stays on the input.
- R3: The class code selects the units. Code 0 selects the integer unit (index 0). Code 1 selects multiplier index 1 if it is free, and otherwise index 2. Code 2 selects the adder (index 3). Code 3 selects the divider (index 4). Bit i of each grant vector belongs to unit index i.
- R4: A busy unit that has not yet read its operands asserts its `rd_grant` bit exactly when both source ready flags are set, and does so for one cycle only. With no pending writers, this is the cycle right after acceptance. A source that has a pending writer at issue waits for that writer's write grant.
- R5: Several units may receive `rd_grant` in the same cycle.
- R6: A unit becomes eligible to write LAT+1 cycles after its `rd_grant` cycle, where LAT is its latency (defaults: integer 1, multiplier 7, adder 4, divider 24). A unit never has `rd_grant` and `wr_grant` in the same cycle.
- R7: A unit that has finished execution has its write held while any other busy unit names the finished unit's destination as a source whose ready flag is still set, meaning that unit has not yet read the old value. `wr_grant` rises in the first cycle without such a reader.
- R8: On a write grant, the unit is free from the next cycle on, and its destination's table entry is cleared. Every waiting unit whose producer for a source is the writing unit has that source marked ready, so its `rd_grant` can come in the next cycle. After a unit reads, its ready flags are cleared and it no longer holds back writers.
- R9: If an instruction is accepted in the same cycle that the producer of one of its sources receives `wr_grant`, that source is treated as ready at issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is presented |
| in_op | input | 2 | Operation class: 0 integer, 1 multiply, 2 add, 3 divide |
| in_dst | input | REG_W | Destination register number |
| in_src1 | input | REG_W | First source register number |
| in_src2 | input | REG_W | Second source register number |
| issue_ready | output | 1 | The presented instruction is accepted at the next edge |
| rd_grant | output | 5 | Per-unit operand read permission |
| wr_grant | output | 5 | Per-unit result write permission |

## Verification
A wrong ready flag shows up as a `rd_grant` bit that comes early, comes late or never comes. A stale producer field shows up as a reader that is woken by the wrong unit's write. A counter that is off by one moves the `wr_grant` bit by a cycle relative to its `rd_grant`. A missed WAR reader lets `wr_grant` rise while the reader's `rd_grant` is still ahead of it, or in the same cycle as that grant. A result table entry that is not cleared holds `issue_ready` low for good on any later write to that register. The bench compares all three outputs against its own model in every cycle, so a fault of this kind is reported in the first cycle where the outputs differ. That is no later than the next grant that depends on the corrupted field.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int NU     = 5;
  localparam int UNIT_W = 3;

  typedef enum logic [1:0] {
    OP_INT = 2'd0,
    OP_MUL = 2'd1,
    OP_ADD = 2'd2,
    OP_DIV = 2'd3
  } op_e;

  typedef struct packed {
    logic              ok;
    logic [UNIT_W-1:0] idx;
  } pick_t;

  // Choose the unit for an operation class given the busy vector.
  function automatic pick_t pick_unit(op_e op, logic [NU-1:0] busy);
    pick_t p;
    p.ok  = 1'b0;
    p.idx = '0;
    case (op)
      OP_INT: begin p.idx = 3'd0; p.ok = !busy[0]; end
      OP_MUL: begin
        if (!busy[1])      begin p.idx = 3'd1; p.ok = 1'b1; end
        else if (!busy[2]) begin p.idx = 3'd2; p.ok = 1'b1; end
        else               begin p.idx = 3'd1; p.ok = 1'b0; end
      end
      OP_ADD: begin p.idx = 3'd3; p.ok = !busy[3]; end
      default: begin p.idx = 3'd4; p.ok = !busy[4]; end
    endcase
    return p;
  endfunction

  // Latency of unit index u from the class latencies.
  function automatic int unit_lat(int u, int l_int, int l_mul, int l_add, int l_div);
    if (u == 0) return l_int;
    if (u <= 2) return l_mul;
    if (u == 3) return l_add;
    return l_div;
  endfunction

  function automatic int max4(int a, int b, int c, int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/sb_fu_slot.sv
module sb_fu_slot #(
  parameter int REG_W  = 5,
  parameter int UNIT_W = 3,
  parameter int NU     = 5,
  parameter int CNT_W  = 5,
  parameter int LAT    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_en,
  input  logic [REG_W-1:0]  iss_fi,
  input  logic [REG_W-1:0]  iss_fj,
  input  logic [REG_W-1:0]  iss_fk,
  input  logic [UNIT_W-1:0] iss_qj,
  input  logic [UNIT_W-1:0] iss_qk,
  input  logic              iss_rj,
  input  logic              iss_rk,
  input  logic [NU-1:0]     wr_all,
  input  logic              rd_go,
  input  logic              wr_go,
  output logic              busy,
  output logic [REG_W-1:0]  fi,
  output logic [REG_W-1:0]  fj,
  output logic [REG_W-1:0]  fk,
  output logic              rj,
  output logic              rk,
  output logic              rd_req,
  output logic              exec_done
);
  logic [UNIT_W-1:0] qj, qk;
  logic              read_done;
  logic [CNT_W-1:0]  cnt;
  logic              wake_j, wake_k;

  // Producer of a still-unread source writes this cycle.
  assign wake_j = busy && !read_done && !rj && wr_all[qj];
  assign wake_k = busy && !read_done && !rk && wr_all[qk];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      fi        <= '0;
      fj        <= '0;
      fk        <= '0;
      qj        <= '0;
      qk        <= '0;
      rj        <= 1'b0;
      rk        <= 1'b0;
      read_done <= 1'b0;
      cnt       <= '0;
    end else if (issue_en) begin
      busy      <= 1'b1;
      fi        <= iss_fi;
      fj        <= iss_fj;
      fk        <= iss_fk;
      qj        <= iss_qj;
      qk        <= iss_qk;
      rj        <= iss_rj;
      rk        <= iss_rk;
      read_done <= 1'b0;
      cnt       <= '0;
    end else begin
      if (wr_go) busy <= 1'b0;
      if (rd_go) begin
        read_done <= 1'b1;
        rj        <= 1'b0;
        rk        <= 1'b0;
        cnt       <= CNT_W'(LAT);
      end else begin
        if (wake_j) rj <= 1'b1;
        if (wake_k) rk <= 1'b1;
        if (cnt != '0) cnt <= cnt - 1'b1;
      end
    end
  end

  assign rd_req    = busy && !read_done && rj && rk;
  assign exec_done = busy && read_done && (cnt == '0);
endmodule

// File: rtl/sb_result_tbl.sv
module sb_result_tbl #(
  parameter int NREG   = 32,
  parameter int REG_W  = 5,
  parameter int NU     = 5,
  parameter int UNIT_W = 3,
  parameter int NQ     = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         set_en,
  input  logic [REG_W-1:0]             set_reg,
  input  logic [UNIT_W-1:0]            set_unit,
  input  logic [NU-1:0]                clr_en,
  input  logic [NU-1:0][REG_W-1:0]     clr_reg,
  input  logic [NQ-1:0][REG_W-1:0]     q_reg,
  output logic [NQ-1:0]                q_pend,
  output logic [NQ-1:0][UNIT_W-1:0]    q_unit
);
  logic [NREG-1:0]             pend;
  logic [NREG-1:0][UNIT_W-1:0] owner;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend  <= '0;
      owner <= '0;
    end else begin
      for (int u = 0; u < NU; u++)
        if (clr_en[u]) pend[clr_reg[u]] <= 1'b0;
      if (set_en) begin
        pend[set_reg]  <= 1'b1;
        owner[set_reg] <= set_unit;
      end
    end
  end

  for (genvar i = 0; i < NQ; i++) begin : g_look
    assign q_pend[i] = pend[q_reg[i]];
    assign q_unit[i] = owner[q_reg[i]];
  end
endmodule

// File: rtl/sb_scoreboard.sv
module sb_scoreboard #(
  parameter int NREG    = 32,
  parameter int REG_W   = $clog2(NREG),
  parameter int LAT_INT = 1,
  parameter int LAT_MUL = 7,
  parameter int LAT_ADD = 4,
  parameter int LAT_DIV = 24
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  input  logic [1:0]             in_op,
  input  logic [REG_W-1:0]       in_dst,
  input  logic [REG_W-1:0]       in_src1,
  input  logic [REG_W-1:0]       in_src2,
  output logic                   issue_ready,
  output logic [sb_pkg::NU-1:0]  rd_grant,
  output logic [sb_pkg::NU-1:0]  wr_grant
);
  import sb_pkg::*;

  localparam int MAXL  = max4(LAT_INT, LAT_MUL, LAT_ADD, LAT_DIV);
  localparam int CNT_W = $clog2(MAXL + 1);

  logic [NU-1:0]             busy, rd_req, exec_done, war_hold, rj, rk;
  logic [NU-1:0][REG_W-1:0]  fi, fj, fk;
  logic [2:0][REG_W-1:0]     q_reg;
  logic [2:0]                q_pend;
  logic [2:0][UNIT_W-1:0]    q_unit;
  pick_t                     pick;
  logic                      issue_fire;
  logic [UNIT_W-1:0]         issue_unit;
  logic                      src1_rdy, src2_rdy;

  assign pick        = pick_unit(op_e'(in_op), busy);
  assign q_reg       = {in_src2, in_src1, in_dst};
  assign issue_ready = pick.ok && !q_pend[0];
  assign issue_fire  = in_valid && issue_ready;
  assign issue_unit  = pick.idx;

  // A source is ready at issue when nobody will write it, or its writer writes now.
  assign src1_rdy = !q_pend[1] || wr_grant[q_unit[1]];
  assign src2_rdy = !q_pend[2] || wr_grant[q_unit[2]];

  sb_result_tbl #(
    .NREG(NREG), .REG_W(REG_W), .NU(NU), .UNIT_W(UNIT_W), .NQ(3)
  ) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .set_en(issue_fire), .set_reg(in_dst), .set_unit(issue_unit),
    .clr_en(wr_grant), .clr_reg(fi),
    .q_reg(q_reg), .q_pend(q_pend), .q_unit(q_unit)
  );

  for (genvar u = 0; u < NU; u++) begin : g_slot
    sb_fu_slot #(
      .REG_W(REG_W), .UNIT_W(UNIT_W), .NU(NU), .CNT_W(CNT_W),
      .LAT(unit_lat(u, LAT_INT, LAT_MUL, LAT_ADD, LAT_DIV))
    ) u_slot (
      .clk(clk), .rst_n(rst_n),
      .issue_en(issue_fire && (issue_unit == UNIT_W'(u))),
      .iss_fi(in_dst), .iss_fj(in_src1), .iss_fk(in_src2),
      .iss_qj(q_unit[1]), .iss_qk(q_unit[2]),
      .iss_rj(src1_rdy), .iss_rk(src2_rdy),
      .wr_all(wr_grant), .rd_go(rd_grant[u]), .wr_go(wr_grant[u]),
      .busy(busy[u]), .fi(fi[u]), .fj(fj[u]), .fk(fk[u]),
      .rj(rj[u]), .rk(rk[u]),
      .rd_req(rd_req[u]), .exec_done(exec_done[u])
    );
  end

  // WAR: another busy unit still has to read the old value of this unit's destination.
  always_comb begin
    war_hold = '0;
    for (int u = 0; u < NU; u++)
      for (int v = 0; v < NU; v++)
        if (v != u && busy[v] &&
            ((rj[v] && fj[v] == fi[u]) || (rk[v] && fk[v] == fi[u])))
          war_hold[u] = 1'b1;
  end

  assign rd_grant = rd_req;
  assign wr_grant = exec_done & ~war_hold;
endmodule

// File: rtl/sb_scoreboard_chk.sv
module sb_scoreboard_chk #(
  parameter int NU     = 5,
  parameter int UNIT_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NU-1:0]     busy,
  input logic [NU-1:0]     rd_grant,
  input logic [NU-1:0]     wr_grant,
  input logic [NU-1:0]     exec_done,
  input logic              issue_fire,
  input logic [UNIT_W-1:0] issue_unit
);
  AST_ISSUE_TO_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |-> !busy[issue_unit]); // R2
  AST_ISSUE_TAKES_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |=> busy[$past(issue_unit)]); // R3
  AST_READ_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (|rd_grant) |=> ((rd_grant & $past(rd_grant)) == '0)); // R4
  AST_PHASE_SPLIT: assert property (@(posedge clk) disable iff (!rst_n)
    ((rd_grant & wr_grant) == '0)); // R6
  AST_WRITE_AFTER_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_grant & ~exec_done) == '0)); // R7
  AST_WRITE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_grant) |=> ((busy & $past(wr_grant)) == '0)); // R8
endmodule

bind sb_scoreboard sb_scoreboard_chk #(
  .NU(sb_pkg::NU), .UNIT_W(sb_pkg::UNIT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .rd_grant(rd_grant),
  .wr_grant(wr_grant), .exec_done(exec_done),
  .issue_fire(issue_fire), .issue_unit(issue_unit)
);

// File: tb/sb_scoreboard_bench.sv
`timescale 1ns/1ps
module sb_scoreboard_bench;
  localparam int NU = 5;
  localparam int RW = 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [1:0]    in_op = '0;
  logic [RW-1:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
  logic          issue_ready;
  logic [NU-1:0] rd_grant, wr_grant;

  int n_checks = 0;
  int n_fails  = 0;
  int cyc      = 0;

  always #2 clk = ~clk;

  sb_scoreboard u_sb_scoreboard (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
    .issue_ready(issue_ready), .rd_grant(rd_grant), .wr_grant(wr_grant)
  );

  // Bench model of the scoreboard state, derived from the requirements.
  int lat [NU] = '{1, 7, 7, 4, 24};
  bit m_busy [NU], m_read [NU], m_rj [NU], m_rk [NU];
  int m_fi [NU], m_fj [NU], m_fk [NU], m_qj [NU], m_qk [NU], m_cnt [NU];
  bit t_pend [32];
  int t_unit [32];

  task automatic check(string tag, int got, int exp);
    n_checks++;
    if (got != exp) begin
      n_fails++;
      $display("FAIL %s cycle %0d: got %0h expected %0h", tag, cyc, got, exp);
    end
  endtask

  function automatic int model_pick(int op);
    case (op)
      0: return m_busy[0] ? -1 : 0;
      1: return !m_busy[1] ? 1 : (!m_busy[2] ? 2 : -1);
      2: return m_busy[3] ? -1 : 3;
      default: return m_busy[4] ? -1 : 4;
    endcase
  endfunction

  function automatic bit has_war_reader(int u);
    for (int v = 0; v < NU; v++)
      if (v != u && m_busy[v] && !m_read[v] &&
          ((m_rj[v] && m_fj[v] == m_fi[u]) || (m_rk[v] && m_fk[v] == m_fi[u])))
        return 1'b1;
    return 1'b0;
  endfunction

  task automatic model_reset();
    for (int u = 0; u < NU; u++) begin
      m_busy[u] = 0; m_read[u] = 0; m_rj[u] = 0; m_rk[u] = 0;
      m_fi[u] = 0; m_fj[u] = 0; m_fk[u] = 0; m_qj[u] = 0; m_qk[u] = 0; m_cnt[u] = 0;
    end
    for (int r = 0; r < 32; r++) begin t_pend[r] = 0; t_unit[r] = 0; end
  endtask

  // One cycle: drive, compare at mid-cycle, advance the model.
  task automatic cycle(bit v, int op, int d, int s1, int s2, string tag, output bit acc);
    bit [NU-1:0] e_rd, e_wr;
    int  pu;
    bit  e_ir, r1, r2;
    @(negedge clk);
    cyc++;
    in_valid = v; in_op = op[1:0]; in_dst = d[RW-1:0];
    in_src1 = s1[RW-1:0]; in_src2 = s2[RW-1:0];
    #0.5;
    e_rd = '0; e_wr = '0;
    for (int u = 0; u < NU; u++) begin
      e_rd[u] = m_busy[u] && !m_read[u] && m_rj[u] && m_rk[u];
      e_wr[u] = m_busy[u] && m_read[u] && m_cnt[u] == 0 && !has_war_reader(u);
    end
    pu   = model_pick(op);
    e_ir = (pu >= 0) && !t_pend[d];
    check({"R2 issue_ready ", tag}, issue_ready, e_ir);
    check({"R4 rd_grant ", tag}, rd_grant, e_rd);
    check({"R7 wr_grant ", tag}, wr_grant, e_wr);
    acc = v && e_ir;
    // R9: a source whose producer writes in this cycle is ready at issue.
    r1 = !t_pend[s1] || e_wr[t_unit[s1]];
    r2 = !t_pend[s2] || e_wr[t_unit[s2]];
    for (int u = 0; u < NU; u++) begin
      if (e_wr[u]) begin m_busy[u] = 0; t_pend[m_fi[u]] = 0; end
      if (e_rd[u]) begin
        m_read[u] = 1; m_rj[u] = 0; m_rk[u] = 0; m_cnt[u] = lat[u];
      end else begin
        if (m_busy[u] && !m_read[u] && !m_rj[u] && e_wr[m_qj[u]]) m_rj[u] = 1;
        if (m_busy[u] && !m_read[u] && !m_rk[u] && e_wr[m_qk[u]]) m_rk[u] = 1;
        if (m_cnt[u] > 0) m_cnt[u]--;
      end
    end
    if (acc) begin
      m_busy[pu] = 1; m_read[pu] = 0; m_cnt[pu] = 0;
      m_fi[pu] = d; m_fj[pu] = s1; m_fk[pu] = s2;
      m_qj[pu] = t_unit[s1]; m_qk[pu] = t_unit[s2];
      m_rj[pu] = r1; m_rk[pu] = r2;
      t_pend[d] = 1; t_unit[d] = pu;
    end
  endtask

  function automatic bit model_idle();
    for (int u = 0; u < NU; u++) if (m_busy[u]) return 1'b0;
    return 1'b1;
  endfunction

  int p_op [16], p_d [16], p_s1 [16], p_s2 [16];

  // Feed a program in order, holding each instruction until accepted, then drain.
  task automatic run_prog(int n, string tag);
    bit acc;
    int k = 0, guard = 0;
    while (k < n && guard < 2000) begin
      cycle(1'b1, p_op[k], p_d[k], p_s1[k], p_s2[k], tag, acc);
      if (acc) k++;
      guard++;
    end
    guard = 0;
    while (!model_idle() && guard < 500) begin
      cycle(1'b0, 0, 0, 0, 0, tag, acc);
      guard++;
    end
    check({"drain ", tag}, model_idle(), 1);
  endtask

  task automatic ld(int i, int op, int d, int s1, int s2);
    p_op[i] = op; p_d[i] = d; p_s1[i] = s1; p_s2[i] = s2;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin : stim
    bit acc;
    int seed;
    seed = $urandom(32'd2718);
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state.
    in_valid = 1'b1; in_op = 2'd3; in_dst = 5'd9;
    #0.5;
    check("R1 issue_ready after reset", issue_ready, 1);
    check("R1 rd_grant after reset", rd_grant, 0);
    check("R1 wr_grant after reset", wr_grant, 0);
    in_valid = 1'b0;

    // R3 + R2: three multiplies, the third waits for a free multiplier.
    ld(0, 1, 1, 8, 9); ld(1, 1, 2, 8, 9); ld(2, 1, 3, 8, 9);
    run_prog(3, "R3 mul mapping");

    // R5: independent instructions read in the same cycle after a shared producer writes.
    ld(0, 0, 4, 10, 11); ld(1, 2, 5, 4, 12); ld(2, 1, 6, 4, 13); ld(3, 3, 7, 4, 4);
    run_prog(4, "R5 parallel read");

    // R6: single instructions per class, latency from rd to wr.
    ld(0, 0, 1, 2, 3); ld(1, 2, 4, 5, 6); ld(2, 1, 7, 8, 9); ld(3, 3, 10, 11, 12);
    run_prog(4, "R6 latency");

    // R7: a short add must not overwrite r8 before the waiting multiply reads it.
    ld(0, 3, 0, 2, 4); ld(1, 1, 10, 0, 8); ld(2, 2, 8, 8, 14);
    run_prog(3, "R7 war hold");

    // R2 WAW then R8 wake-up: second writer of r3 waits; reader of r3 wakes on write.
    ld(0, 2, 3, 1, 1); ld(1, 0, 3, 2, 2); ld(2, 1, 9, 3, 3);
    run_prog(3, "R8 waw wake");

    // Random mix with few registers; R9 same-cycle forwarding arises here.
    begin
      int k = 0, op, d, s1, s2;
      op = $urandom_range(3); d = $urandom_range(7);
      s1 = $urandom_range(7); s2 = $urandom_range(7);
      while (k < 600) begin
        bit v;
        v = ($urandom_range(3) != 0);
        cycle(v, op, d, s1, s2, "R9 random", acc);
        if (acc) begin
          k++;
          op = $urandom_range(3); d = $urandom_range(7);
          s1 = $urandom_range(7); s2 = $urandom_range(7);
        end
      end
      k = 0;
      while (!model_idle() && k < 500) begin
        cycle(1'b0, 0, 0, 0, 0, "R9 drain", acc);
        k++;
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule